// File: doc/BRIEF.md
# SMBASE Protected Window Lock Controller

This block holds a single byte-wide feature register through which firmware finds out whether RAM can be shielded at the fixed SMBASE range, and then seals that range. Firmware first writes a magic query byte. The register answers with a capability code and narrows its write mask to one lock bit. A later write that sets the lock bit seals the register until reset. From then on the block raises two enables. One makes ordinary (non-SMM) accesses to the range hit a blackhole, which returns all ones on reads and drops writes. The other opens a RAM window to the same range for SMM accesses.

A strap input says whether the feature is fitted. With the strap low, the byte is plain masked storage and the window is never opened. The block also decodes an access address with its SMM flag and reports whether that access is blackholed or routed to RAM. The configuration write port is a plain strobe with no back-pressure: a write is taken on every clock edge where `cfg_we` is high, and no ready signal exists.

Top module: `smbase_lock_ctl`

## Requirements
- R1: After reset, `cfg_rdata` is 0x00, `cfg_wmask` is 0xFF, and `bh_en`, `smm_win_en`, `acc_bh_hit` and `acc_ram_hit` are all 0.
- R2: With `strap_en` low, a write stores `(rdata & ~wmask) | (wdata & wmask)` verbatim, and `bh_en` and `smm_win_en` stay 0.
- R3: With `strap_en` high, a write whose masked merge equals the query byte 0xFF makes `cfg_rdata` read 0x01 (in-RAM capability) and `cfg_wmask` read 0x02 (only lock bit 1 writable), both on the next cycle.
- R4: With `strap_en` high and `cfg_wmask` still 0xFF, a write whose merge is not 0xFF is discarded and `cfg_rdata` reads 0x00 on the next cycle.
- R5: With `strap_en` high and `cfg_wmask` 0x02, a write with bit 1 set locks the block. On the next cycle `cfg_rdata` is 0x02, `cfg_wmask` is 0x00, and `bh_en` and `smm_win_en` are 1.
- R6: Once locked, no write changes `cfg_rdata`, `cfg_wmask` or the lock until reset.
- R7: After a query, a write with bit 1 clear leaves `cfg_rdata` at 0x01 and `cfg_wmask` at 0x02, with both enables 0.
- R8: The enables are 1 only while locked and `strap_en` is high. While they are 1, an access with address in 0x30000..0x4FFFF raises `acc_bh_hit` if `acc_smm` is 0 and `acc_ram_hit` if `acc_smm` is 1. Otherwise both hit outputs are 0. The two hits are never high together.
- R9: The access decode is combinational on the registered lock state. An access presented in the same cycle as the locking write is decoded as unlocked, and the same access is decoded as locked one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Feature-present strap |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 8 | Register write byte |
| cfg_rdata | output | 8 | Current register value |
| cfg_wmask | output | 8 | Current write mask |
| bh_en | output | 1 | Normal-mode blackhole enable over the SMBASE range |
| smm_win_en | output | 1 | SMM-mode RAM window enable over the SMBASE range |
| acc_addr | input | ADDR_W | Address of the access being decoded |
| acc_smm | input | 1 | Access is made in SMM |
| acc_bh_hit | output | 1 | Access is blackholed |
| acc_ram_hit | output | 1 | Access is routed to protected RAM |

## Verification
The configuration write and the access decode can fall in the same cycle. The locking write is the case that matters, because it changes the decode result. The bench presents a range access together with the lock write and expects the unlocked result before the clock edge. It expects the locked routing, chosen by the SMM flag, in the cycle after. Random runs also issue accesses on every write cycle, including writes while locked, and compare the hits each cycle with a bench model of the register.

// File: rtl/smbase_lock_pkg.sv
package smbase_lock_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t value;
    byte_t wmask;
    logic  locked;
  } lock_state_t;

  localparam byte_t MASK_OPEN = 8'hFF;
endpackage

// File: rtl/smbase_wr_merge.sv
module smbase_wr_merge
  import smbase_lock_pkg::*;
#(
  parameter byte_t QUERY_VAL = 8'hFF,
  parameter byte_t CAP_VAL   = 8'h01,
  parameter int unsigned LOCK_BIT = 1
) (
  input  logic        strap,
  input  byte_t       wdata,
  input  lock_state_t cur,
  output lock_state_t nxt
);
  localparam byte_t LOCK_MSK = byte_t'(1) << LOCK_BIT;

  byte_t merged;
  byte_t discarded;

  always_comb begin
    merged    = (cur.value & ~cur.wmask) | (wdata & cur.wmask);
    discarded = (cur.wmask == MASK_OPEN) ? '0 : merged;
    nxt       = cur;
    if (!strap) begin
      nxt.value = merged;
    end else if (merged == QUERY_VAL) begin
      nxt.value = CAP_VAL;
      nxt.wmask = LOCK_MSK;
    end else if ((discarded & LOCK_MSK) != '0) begin
      nxt.value  = LOCK_MSK;
      nxt.wmask  = cur.wmask & ~LOCK_MSK;
      nxt.locked = 1'b1;
    end else begin
      nxt.value = discarded;
    end
  end
endmodule

// File: rtl/smbase_range_decode.sv
module smbase_range_decode #(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
  input  logic              active,
  input  logic [ADDR_W-1:0] addr,
  input  logic              smm,
  output logic              bh_hit,
  output logic              ram_hit
);
  localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + WIN_SIZE - 1'b1;

  logic in_win;

  always_comb begin
    in_win  = (addr >= WIN_BASE) && (addr <= WIN_LAST);
    bh_hit  = active && in_win && !smm;
    ram_hit = active && in_win && smm;
  end

  always_comb begin
    p_hits_exclusive_r8: assert (!(bh_hit && ram_hit));
  end
endmodule

// File: rtl/smbase_lock_ctl.sv
module smbase_lock_ctl
  import smbase_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000,
  parameter logic [7:0] QUERY_VAL = 8'hFF,
  parameter logic [7:0] CAP_VAL   = 8'h01,
  parameter int unsigned LOCK_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_en,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic [7:0]        cfg_wmask,
  output logic              bh_en,
  output logic              smm_win_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_smm,
  output logic              acc_bh_hit,
  output logic              acc_ram_hit
);
  localparam byte_t LOCK_MSK = byte_t'(1) << LOCK_BIT;

  lock_state_t st_q, st_d;
  logic        win_active;

  smbase_wr_merge #(
    .QUERY_VAL(QUERY_VAL), .CAP_VAL(CAP_VAL), .LOCK_BIT(LOCK_BIT)
  ) u_merge (
    .strap(strap_en), .wdata(cfg_wdata), .cur(st_q), .nxt(st_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '{value: '0, wmask: MASK_OPEN, locked: 1'b0};
    end else if (cfg_we) begin
      st_q <= st_d;
    end
  end

  assign win_active = st_q.locked && strap_en;
  assign cfg_rdata  = st_q.value;
  assign cfg_wmask  = st_q.wmask;
  assign bh_en      = win_active;
  assign smm_win_en = win_active;

  smbase_range_decode #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
  ) u_dec (
    .active(win_active), .addr(acc_addr), .smm(acc_smm),
    .bh_hit(acc_bh_hit), .ram_hit(acc_ram_hit)
  );

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.locked |=> st_q.locked && $stable(cfg_rdata) && $stable(cfg_wmask));

  p_locked_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q.locked |-> (cfg_rdata == LOCK_MSK) && (cfg_wmask == '0));

  p_query_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && strap_en && cfg_wmask == MASK_OPEN && cfg_wdata == QUERY_VAL)
      |=> (cfg_rdata == CAP_VAL) && (cfg_wmask == LOCK_MSK));

  p_discard_unqueried_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && strap_en && cfg_wmask == MASK_OPEN && cfg_wdata != QUERY_VAL)
      |=> cfg_rdata == '0);

  p_strap_off_dark_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |-> !bh_en && !smm_win_en);

  p_mask_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wmask == MASK_OPEN) || (cfg_wmask == LOCK_MSK) || (cfg_wmask == '0));
endmodule

// File: tb/smbase_lock_ctl_test.sv
module smbase_lock_ctl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, strap_en = 0, cfg_we = 0, acc_smm = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [31:0] acc_addr = 0;
  logic [7:0]  cfg_rdata, cfg_wmask;
  logic        bh_en, smm_win_en, acc_bh_hit, acc_ram_hit;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_val, m_msk;
  logic       m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbase_lock_ctl uut (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic in_win(logic [31:0] a);
    return a >= 32'h30000 && a <= 32'h4FFFF;
  endfunction

  task automatic model_write(logic s, logic [7:0] w);
    logic [7:0] mg;
    mg = (m_val & ~m_msk) | (w & m_msk);
    if (!s) m_val = mg;
    else if (mg == 8'hFF) begin m_val = 8'h01; m_msk = 8'h02; end
    else begin
      m_val = (m_msk == 8'hFF) ? 8'h00 : mg;
      if (m_val[1]) begin m_val = 8'h02; m_msk &= ~8'h02; m_lock = 1; end
    end
  endtask

  task automatic check_all(string tag);
    logic act;
    act = m_lock && strap_en;
    chk({tag, " rdata"}, cfg_rdata, m_val);
    chk({tag, " wmask"}, cfg_wmask, m_msk);
    chk({tag, " R8 bh_en"}, bh_en, act);
    chk({tag, " R8 win_en"}, smm_win_en, act);
    chk({tag, " R8 bh_hit"}, acc_bh_hit, act && in_win(acc_addr) && !acc_smm);
    chk({tag, " R8 ram_hit"}, acc_ram_hit, act && in_win(acc_addr) && acc_smm);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cfg_we = 0;
    m_val = 0; m_msk = 8'hFF; m_lock = 0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic wr(logic [7:0] w, string tag);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = w;
    model_write(strap_en, w);
    @(negedge clk);
    cfg_we = 0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    // R1 reset state
    strap_en = 1; acc_addr = 32'h30000;
    do_reset();
    check_all("R1");
    // R4 unqueried write discarded
    wr(8'h02, "R4");
    wr(8'h5A, "R4");
    // R3 query, R7 non-lock write after query
    wr(8'hFF, "R3");
    wr(8'hFD, "R7");
    // R9: locking write and in-range access in same cycle
    @(negedge clk);
    cfg_we = 1; cfg_wdata = 8'h02; acc_addr = 32'h4FFFF; acc_smm = 0;
    #1 chk("R9 pre-edge bh_hit", acc_bh_hit, 0);
    model_write(1, 8'h02);
    @(negedge clk); cfg_we = 0;
    check_all("R5 R9");
    acc_smm = 1; #1 check_all("R8 smm");
    acc_addr = 32'h50000; #1 check_all("R8 outside");
    acc_addr = 32'h2FFFF; #1 check_all("R8 below");
    // R6 locked writes ignored
    wr(8'hFF, "R6");
    wr(8'h00, "R6");
    // R2 strap off: plain storage
    strap_en = 0;
    do_reset();
    wr(8'hFF, "R2");
    wr(8'h02, "R2");
    wr(8'hA5, "R2");
    // random episodes
    for (int ep = 0; ep < 60; ep++) begin
      strap_en = ($urandom % 5) != 0;
      do_reset();
      for (int k = 0; k < 12; k++) begin
        logic [7:0] w;
        case ($urandom % 4)
          0: w = 8'hFF;
          1: w = 8'h02;
          default: w = 8'($urandom);
        endcase
        acc_addr = ($urandom % 2) ? 32'h30000 + ($urandom % 32'h20000) : $urandom % 32'h80000;
        acc_smm = $urandom % 2;
        if (($urandom % 16) == 0) strap_en = ~strap_en;
        wr(w, "R2/R3/R4/R5/R6/R7 random");
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule